// File: doc/BRIEF.md
# Fast-to-Slow Configuration Sync Trigger

This block moves a group of configuration settings from a fast clock domain into a slow one, and only when software asks for it. The group is made of control bits, a wakeup-enable mask and a reset-enable mask. Software programs these settings in the fast domain at any time. The slow domain goes on using the settings it last received until a transfer is triggered.

A write of 1 to the sync bit starts a transfer. The fast side takes a snapshot of the settings and flips a request toggle. The slow side sees the toggle through a two-flop synchronizer, loads the snapshot into its holding registers and flips an acknowledge toggle back. The sync bit reads 1 while the transfer is in flight and clears itself once the acknowledge returns. Software polls for that clear before it relies on the new values.

Top module: `cfg_sync_xfer`

## Requirements
- R1: After both resets, `sync_busy_o` is 0 and all slow-domain outputs are 0.
- R2: While no transfer is in flight, the slow-domain outputs keep their value whatever `ctrl_i`, `wake_en_i` and `rst_en_i` do.
- R3: A fast-clock cycle with `sync_wr_i`=1 and `sync_wdata_i`=1 while idle makes `sync_busy_o` read 1 from the next fast-clock cycle.
- R4: When a transfer completes, the slow outputs equal the settings present in the fast cycle of the triggering write, even if the inputs change afterwards. The packed bundle is {ctrl, wake_en, rst_en}, with rst_en in the lowest bits.
- R5: `sync_busy_o` returns to 0 within 6 slow-clock periods of the triggering write.
- R6: The slow-domain holding registers load once for each transfer and are stable in every other slow cycle.
- R7: A write of 1 while a transfer is in flight has no effect: it starts no second transfer, and the settings it presents never reach the slow outputs.
- R8: A write of 0 to the sync bit has no effect: `sync_busy_o` stays 0 and the slow outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Fast-domain asynchronous reset, active low |
| clk_slow_i | input | 1 | Slow clock |
| rst_slow_ni | input | 1 | Slow-domain asynchronous reset, active low |
| sync_wr_i | input | 1 | Write strobe for the sync bit |
| sync_wdata_i | input | 1 | Value written to the sync bit |
| ctrl_i | input | CtrlW | Control bits, fast domain |
| wake_en_i | input | NumWake | Wakeup-enable mask, fast domain |
| rst_en_i | input | NumRst | Reset-enable mask, fast domain |
| sync_busy_o | output | 1 | Sync bit readback: 1 while a transfer is in flight |
| slow_ctrl_o | output | CtrlW | Control bits, slow domain |
| slow_wake_en_o | output | NumWake | Wakeup-enable mask, slow domain |
| slow_rst_en_o | output | NumRst | Reset-enable mask, slow domain |

## Verification
The hardest case to reach from the ports is a second sync write, or a change of the settings, that lands while the toggle is still crossing the two synchronizers. Only then does the snapshot and the ignore rule make a difference. The bench uses clock periods that share no common ratio, so the phase between the two clocks drifts from one transfer to the next. It also sweeps every value of the 8-bit bundle. Just after each triggering write it changes the inputs to their complement. In a dedicated pass it issues a second write in the middle of the transfer, then waits long enough that a stray second transfer would show up at the slow outputs.

// File: rtl/cfg_sync_pkg.sv
package cfg_sync_pkg;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/cfg_sync_flop.sv
module cfg_sync_flop #(
  parameter int unsigned Stages = cfg_sync_pkg::SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [Stages-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[Stages-2:0], d_i};
  end

  assign q_o = stg_q[Stages-1];
endmodule

// File: rtl/cfg_sync_src.sv
module cfg_sync_src #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic         wr_data_i,
  input  logic [W-1:0] cfg_i,
  input  logic         ack_tgl_i,
  output logic         req_tgl_o,
  output logic [W-1:0] hold_o,
  output logic         busy_o
);
  logic         req_q;
  logic [W-1:0] hold_q;
  logic         start;

  assign busy_o = req_q ^ ack_tgl_i;
  assign start  = wr_en_i & wr_data_i & ~busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      hold_q <= '0;
    end else if (start) begin
      req_q  <= ~req_q;
      hold_q <= cfg_i;
    end
  end

  assign req_tgl_o = req_q;
  assign hold_o    = hold_q;

  // R3
  start_sets_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i && !busy_o) |=> busy_o);
  // R7
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(hold_q));
  // R7
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && wr_en_i && wr_data_i) |=> $stable(req_q));
  // R8
  zero_write_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_data_i && !busy_o) |=> !busy_o);
endmodule

// File: rtl/cfg_sync_dst.sv
module cfg_sync_dst #(
  parameter int unsigned W        = 8,
  parameter logic [W-1:0] ResetVal = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_i,
  input  logic [W-1:0] hold_i,
  output logic         seen_o,
  output logic [W-1:0] cfg_o
);
  logic         seen_q;
  logic [W-1:0] cfg_q;
  logic         load;

  assign load = req_i ^ seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      cfg_q  <= ResetVal;
    end else if (load) begin
      seen_q <= req_i;
      cfg_q  <= hold_i;
    end
  end

  assign seen_o = seen_q;
  assign cfg_o  = cfg_q;

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == seen_q) |=> $stable(cfg_q));
  // R6
  single_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i != seen_q) |=> (seen_q == $past(req_i)));
endmodule

// File: rtl/cfg_sync_xfer.sv
module cfg_sync_xfer #(
  parameter int unsigned CtrlW   = 3,
  parameter int unsigned NumWake = 3,
  parameter int unsigned NumRst  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clk_slow_i,
  input  logic               rst_slow_ni,
  input  logic               sync_wr_i,
  input  logic               sync_wdata_i,
  input  logic [CtrlW-1:0]   ctrl_i,
  input  logic [NumWake-1:0] wake_en_i,
  input  logic [NumRst-1:0]  rst_en_i,
  output logic               sync_busy_o,
  output logic [CtrlW-1:0]   slow_ctrl_o,
  output logic [NumWake-1:0] slow_wake_en_o,
  output logic [NumRst-1:0]  slow_rst_en_o
);
  localparam int unsigned W = CtrlW + NumWake + NumRst;

  logic [W-1:0] cfg_fast, hold, cfg_slow;
  logic         req_tgl, req_slow, ack_tgl, ack_fast;

  assign cfg_fast = {ctrl_i, wake_en_i, rst_en_i};

  cfg_sync_src #(.W(W)) u_src (
    .clk_i, .rst_ni,
    .wr_en_i   (sync_wr_i),
    .wr_data_i (sync_wdata_i),
    .cfg_i     (cfg_fast),
    .ack_tgl_i (ack_fast),
    .req_tgl_o (req_tgl),
    .hold_o    (hold),
    .busy_o    (sync_busy_o)
  );

  cfg_sync_flop u_req_sync (
    .clk_i (clk_slow_i), .rst_ni (rst_slow_ni), .d_i (req_tgl), .q_o (req_slow)
  );

  cfg_sync_dst #(.W(W)) u_dst (
    .clk_i  (clk_slow_i),
    .rst_ni (rst_slow_ni),
    .req_i  (req_slow),
    .hold_i (hold),
    .seen_o (ack_tgl),
    .cfg_o  (cfg_slow)
  );

  cfg_sync_flop u_ack_sync (
    .clk_i, .rst_ni, .d_i (ack_tgl), .q_o (ack_fast)
  );

  assign {slow_ctrl_o, slow_wake_en_o, slow_rst_en_o} = cfg_slow;
endmodule

// File: tb/cfg_sync_xfer_tb.sv
module cfg_sync_xfer_tb;
  logic clk = 1'b0, clk_slow = 1'b0;
  logic rst_n = 1'b0, rst_slow_n = 1'b0;
  logic wr = 1'b0, wdata = 1'b0;
  logic [7:0] cfg = '0;
  logic busy;
  logic [2:0] s_ctrl, s_wake;
  logic [1:0] s_rst;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;
  always #36.5 clk_slow = ~clk_slow;

  cfg_sync_xfer u_dut (
    .clk_i (clk), .rst_ni (rst_n), .clk_slow_i (clk_slow), .rst_slow_ni (rst_slow_n),
    .sync_wr_i (wr), .sync_wdata_i (wdata),
    .ctrl_i (cfg[7:5]), .wake_en_i (cfg[4:2]), .rst_en_i (cfg[1:0]),
    .sync_busy_o (busy), .slow_ctrl_o (s_ctrl), .slow_wake_en_o (s_wake),
    .slow_rst_en_o (s_rst)
  );

  function automatic logic [7:0] slow_now();
    return {s_ctrl, s_wake, s_rst};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_write(input logic d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0; wdata = 1'b0;
  endtask

  // waits for busy to clear; 6 slow periods = 438 ns < 22 fast cycles
  task automatic wait_idle(input string req);
    int n = 0;
    while (busy === 1'b1 && n < 22) begin @(negedge clk); n++; end
    chk(req, {7'd0, busy}, 8'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual expired expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] last;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; rst_slow_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 busy", {7'd0, busy}, 8'd0);
    chk("R1 slow", slow_now(), 8'd0);
    last = 8'd0;

    // R3 R4 R5 full sweep with inputs complemented after the write
    for (int p = 0; p < 256; p++) begin
      cfg = p[7:0];
      pulse_write(1'b1);
      chk("R3 busy after write", {7'd0, busy}, 8'd1);
      cfg = ~p[7:0];
      wait_idle("R5 busy cleared");
      chk("R4 snapshot", slow_now(), p[7:0]);
      last = p[7:0];
    end

    // R2 inputs wander without a sync
    for (int k = 0; k < 16; k++) begin
      cfg = 8'(k * 37 + 5);
      repeat (5) @(negedge clk);
      chk("R2 slow held", slow_now(), last);
    end

    // R8 write 0
    for (int k = 0; k < 4; k++) begin
      cfg = 8'(k * 91 + 3);
      pulse_write(1'b0);
      chk("R8 busy", {7'd0, busy}, 8'd0);
      repeat (20) @(negedge clk);
      chk("R8 slow", slow_now(), last);
    end

    // R7 second write while in flight
    for (int k = 0; k < 8; k++) begin
      logic [7:0] a;
      a = 8'(k * 29 + 17);
      cfg = a;
      pulse_write(1'b1);
      cfg = ~a;
      repeat (k % 3) @(negedge clk);
      pulse_write(1'b1);
      cfg = 8'h5a ^ a;
      wait_idle("R7 busy cleared");
      repeat (40) @(negedge clk);
      chk("R7 busy stays idle", {7'd0, busy}, 8'd0);
      chk("R7 slow first snapshot", slow_now(), a);
      last = a;
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule